// File: doc/BRIEF.md
# Bank-Aware Memory Request Scheduler

This block sits between a request source and a DRAM command engine. It keeps a small pool of pending memory requests, each carrying a bank index, a row address, a read/write flag and a caller tag. Every cycle it offers at most one request on an issue port with a valid/ready handshake. The command engine supplies, for each bank, whether a row is open, which row that is, and whether the bank is currently busy with an in-progress operation.

A mode input selects the ordering policy. Strict arrival order serves whatever request has waited longest and stalls when that request cannot go. The row-aware policy does four things. It serves reads before buffered writes. It switches to writes once enough writes have piled up. Within the chosen class it prefers requests that hit a bank's open row. It passes over requests whose bank is busy. In all cases, ties are broken by arrival order. Age is a compact per-entry rank that records insertion order, so no two valid entries ever share an age.

Top module: `mem_req_sched`

## Requirements
- R1: After reset the pool is empty, `iss_valid` is 0 and `enq_ready` is 1; an empty pool never raises `iss_valid`.
- R2: The pool accepts up to DEPTH requests; while DEPTH are held `enq_ready` is 0 and a request offered then is dropped and never issued.
- R3: With `sched_mode` = 0 (arrival order), the oldest queued request is offered regardless of row or read/write flag; if its bank is busy, `iss_valid` is 0.
- R4: With `sched_mode` = 1, within the class being served, a request whose bank has an open row equal to its row is offered before any older request that needs a row change.
- R5: With `sched_mode` = 1, among equally preferred requests the oldest is offered.
- R6: With `sched_mode` = 1, a request whose bank has `bank_busy` set is skipped and the next eligible request is offered instead; no issued request ever targets a busy bank.
- R7: With `sched_mode` = 1 and fewer than WR_HIWAT writes queued, no write (`enq_write` = 1) is offered while any read is queued, even when every read is blocked.
- R8: With `sched_mode` = 1 and at least WR_HIWAT writes queued, only writes are offered.
- R9: The offered bank, row, write flag and tag equal those given at enqueue; the offer is held while `iss_ready` is 0, and a request leaves the pool exactly on the cycle `iss_valid` and `iss_ready` are both 1.
- R10: A row hit requires the bank's `bank_open` bit to be 1; a matching row number on a bank whose bit is 0 gives no preference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sched_mode | input | 1 | 0 = arrival order, 1 = row-aware order |
| enq_valid | input | 1 | New request offered |
| enq_ready | output | 1 | Pool has a free entry |
| enq_bank | input | BANK_W | Bank index of new request |
| enq_row | input | ROW_W | Row address of new request |
| enq_write | input | 1 | 1 = write, 0 = read |
| enq_tag | input | TAG_W | Caller tag, returned on issue |
| bank_open | input | BANKS | Per-bank row-open flag |
| bank_row | input | BANKS*ROW_W | Per-bank open row, bank b at bits [b*ROW_W +: ROW_W] |
| bank_busy | input | BANKS | Per-bank in-progress flag |
| iss_valid | output | 1 | A request is offered |
| iss_ready | input | 1 | Engine takes the offered request |
| iss_bank | output | BANK_W | Bank of offered request |
| iss_row | output | ROW_W | Row of offered request |
| iss_write | output | 1 | Write flag of offered request |
| iss_tag | output | TAG_W | Tag of offered request |

## Verification
A corrupted age rank shows up at the issue port within one cycle. The next offer after an enqueue sequence comes out in the wrong tag order, or under arrival-order mode the port stalls because no entry holds the oldest rank. A stale valid bit either replays an already issued tag or lets a dropped request appear, which the bench sees when it drains the pool. A wrong class or hit decision changes which tag is offered in the very cycle the bank status or the write count changes, so each scenario sets status first and checks the offer before the next edge.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
   typedef enum logic {
      MODE_ARRIVAL = 1'b0,
      MODE_ROWAWARE = 1'b1
   } sched_mode_e;
endpackage

// File: rtl/mrs_queue.sv
module mrs_queue #(
   parameter int DEPTH  = 8,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 8,
   parameter int TAG_W  = 8,
   parameter int IDX_W  = 3,
   parameter int CNT_W  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              enq_fire,
   input  logic [BANK_W-1:0]                 enq_bank,
   input  logic [ROW_W-1:0]                  enq_row,
   input  logic                              enq_write,
   input  logic [TAG_W-1:0]                  enq_tag,
   input  logic                              iss_fire,
   input  logic [IDX_W-1:0]                  iss_idx,
   output logic [DEPTH-1:0]                  q_valid,
   output logic [DEPTH-1:0][BANK_W-1:0]      q_bank,
   output logic [DEPTH-1:0][ROW_W-1:0]       q_row,
   output logic [DEPTH-1:0]                  q_write,
   output logic [DEPTH-1:0][TAG_W-1:0]       q_tag,
   output logic [DEPTH-1:0][IDX_W-1:0]       q_rank,
   output logic [CNT_W-1:0]                  occ
);
   logic [IDX_W-1:0] free_idx;
   logic [CNT_W-1:0] new_rank;
   logic [IDX_W-1:0] gone_rank;

   // lowest free slot
   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!q_valid[i]) free_idx = IDX_W'(i);
      end
   end

   always_comb begin
      occ = '0;
      for (int i = 0; i < DEPTH; i++) occ = occ + CNT_W'(q_valid[i]);
   end

   // a newcomer is younger than every survivor
   assign new_rank  = occ - CNT_W'(iss_fire);
   assign gone_rank = q_rank[iss_idx];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic              v_r;
      logic [IDX_W-1:0]  rank_r;
      logic [BANK_W-1:0] bank_r;
      logic [ROW_W-1:0]  row_r;
      logic              wr_r;
      logic [TAG_W-1:0]  tag_r;
      logic              take;
      logic              leave;

      assign take  = enq_fire && (free_idx == IDX_W'(g));
      assign leave = iss_fire && (iss_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_r    <= 1'b0;
            rank_r <= '0;
         end else if (take) begin
            v_r    <= 1'b1;
            rank_r <= new_rank[IDX_W-1:0];
         end else if (leave) begin
            v_r    <= 1'b0;
         end else if (iss_fire && v_r && (rank_r > gone_rank)) begin
            rank_r <= rank_r - 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (take) begin
            bank_r <= enq_bank;
            row_r  <= enq_row;
            wr_r   <= enq_write;
            tag_r  <= enq_tag;
         end
      end

      assign q_valid[g] = v_r;
      assign q_rank[g]  = rank_r;
      assign q_bank[g]  = bank_r;
      assign q_row[g]   = row_r;
      assign q_write[g] = wr_r;
      assign q_tag[g]   = tag_r;
   end
endmodule

// File: rtl/mrs_match.sv
module mrs_match #(
   parameter int DEPTH  = 8,
   parameter int BANKS  = 4,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 8
) (
   input  logic [DEPTH-1:0][BANK_W-1:0] q_bank,
   input  logic [DEPTH-1:0][ROW_W-1:0]  q_row,
   input  logic [BANKS-1:0]             bank_open,
   input  logic [BANKS*ROW_W-1:0]       bank_row,
   input  logic [BANKS-1:0]             bank_busy,
   output logic [DEPTH-1:0]             e_hit,
   output logic [DEPTH-1:0]             e_busy
);
   logic [BANKS-1:0][ROW_W-1:0] rows;
   assign rows = bank_row;

   for (genvar g = 0; g < DEPTH; g++) begin : g_look
      assign e_hit[g]  = bank_open[q_bank[g]] && (rows[q_bank[g]] == q_row[g]);
      assign e_busy[g] = bank_busy[q_bank[g]];
   end
endmodule

// File: rtl/mrs_select.sv
module mrs_select
   import mrs_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int IDX_W    = 3,
   parameter int CNT_W    = 4,
   parameter int WR_HIWAT = 4
) (
   input  sched_mode_e                  mode,
   input  logic [DEPTH-1:0]             q_valid,
   input  logic [DEPTH-1:0]             q_write,
   input  logic [DEPTH-1:0]             e_hit,
   input  logic [DEPTH-1:0]             e_busy,
   input  logic [DEPTH-1:0][IDX_W-1:0]  q_rank,
   output logic                         found,
   output logic [IDX_W-1:0]             sel_idx
);
   logic             rd_any;
   logic [CNT_W-1:0] wr_cnt;
   logic             drain;
   logic             pool_w;
   logic [DEPTH-1:0] cand;
   logic [DEPTH-1:0] hits;
   logic [DEPTH-1:0] pick_set;
   logic             fr_found;
   logic [IDX_W-1:0] fr_idx;
   logic [IDX_W-1:0] fr_rank;
   logic             head_ok;
   logic [IDX_W-1:0] head_idx;

   assign rd_any = |(q_valid & ~q_write);

   always_comb begin
      wr_cnt = '0;
      for (int i = 0; i < DEPTH; i++) wr_cnt = wr_cnt + CNT_W'(q_valid[i] & q_write[i]);
   end

   assign drain  = (wr_cnt >= CNT_W'(WR_HIWAT));
   assign pool_w = drain || !rd_any;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cand
      assign cand[g] = q_valid[g] && !e_busy[g] && (q_write[g] == pool_w);
   end

   assign hits     = cand & e_hit;
   assign pick_set = (|hits) ? hits : cand;

   // oldest member of the preferred set
   always_comb begin
      fr_found = 1'b0;
      fr_idx   = '0;
      fr_rank  = '1;
      for (int i = 0; i < DEPTH; i++) begin
         if (pick_set[i] && (!fr_found || (q_rank[i] < fr_rank))) begin
            fr_found = 1'b1;
            fr_idx   = IDX_W'(i);
            fr_rank  = q_rank[i];
         end
      end
   end

   // strict order: only the rank-0 entry may go
   always_comb begin
      head_ok  = 1'b0;
      head_idx = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (q_valid[i] && (q_rank[i] == '0)) begin
            head_ok  = !e_busy[i];
            head_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      if (mode == MODE_ROWAWARE) begin
         found   = fr_found;
         sel_idx = fr_idx;
      end else begin
         found   = head_ok;
         sel_idx = head_idx;
      end
   end
endmodule

// File: rtl/mem_req_sched.sv
module mem_req_sched
   import mrs_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int BANKS    = 4,
   parameter int ROW_W    = 8,
   parameter int TAG_W    = 8,
   parameter int WR_HIWAT = 4,
   localparam int BANK_W  = $clog2(BANKS),
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sched_mode,
   input  logic                   enq_valid,
   output logic                   enq_ready,
   input  logic [BANK_W-1:0]      enq_bank,
   input  logic [ROW_W-1:0]       enq_row,
   input  logic                   enq_write,
   input  logic [TAG_W-1:0]       enq_tag,
   input  logic [BANKS-1:0]       bank_open,
   input  logic [BANKS*ROW_W-1:0] bank_row,
   input  logic [BANKS-1:0]       bank_busy,
   output logic                   iss_valid,
   input  logic                   iss_ready,
   output logic [BANK_W-1:0]      iss_bank,
   output logic [ROW_W-1:0]       iss_row,
   output logic                   iss_write,
   output logic [TAG_W-1:0]       iss_tag
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (BANKS < 2 || (1 << BANK_W) != BANKS) begin : g_bad_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (WR_HIWAT < 1 || WR_HIWAT > DEPTH) begin : g_bad_hiwat
      $error("WR_HIWAT must lie in 1..DEPTH");
   end
   if (ROW_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("ROW_W and TAG_W must be positive");
   end

   logic [DEPTH-1:0]             q_valid;
   logic [DEPTH-1:0][BANK_W-1:0] q_bank;
   logic [DEPTH-1:0][ROW_W-1:0]  q_row;
   logic [DEPTH-1:0]             q_write;
   logic [DEPTH-1:0][TAG_W-1:0]  q_tag;
   logic [DEPTH-1:0][IDX_W-1:0]  q_rank;
   logic [CNT_W-1:0]             occ;
   logic [DEPTH-1:0]             e_hit;
   logic [DEPTH-1:0]             e_busy;
   logic                         found;
   logic [IDX_W-1:0]             sel_idx;
   logic                         enq_fire;
   logic                         iss_fire;
   sched_mode_e                  mode;

   assign mode      = sched_mode_e'(sched_mode);
   assign enq_ready = (occ != CNT_W'(DEPTH));
   assign enq_fire  = enq_valid && enq_ready;
   assign iss_valid = found;
   assign iss_fire  = found && iss_ready;

   assign iss_bank  = q_bank[sel_idx];
   assign iss_row   = q_row[sel_idx];
   assign iss_write = q_write[sel_idx];
   assign iss_tag   = q_tag[sel_idx];

   mrs_queue #(
      .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W),
      .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_queue (
      .clk(clk), .rst_n(rst_n),
      .enq_fire(enq_fire), .enq_bank(enq_bank), .enq_row(enq_row),
      .enq_write(enq_write), .enq_tag(enq_tag),
      .iss_fire(iss_fire), .iss_idx(sel_idx),
      .q_valid(q_valid), .q_bank(q_bank), .q_row(q_row), .q_write(q_write),
      .q_tag(q_tag), .q_rank(q_rank), .occ(occ)
   );

   mrs_match #(
      .DEPTH(DEPTH), .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W)
   ) u_match (
      .q_bank(q_bank), .q_row(q_row),
      .bank_open(bank_open), .bank_row(bank_row), .bank_busy(bank_busy),
      .e_hit(e_hit), .e_busy(e_busy)
   );

   mrs_select #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .WR_HIWAT(WR_HIWAT)
   ) u_select (
      .mode(mode), .q_valid(q_valid), .q_write(q_write),
      .e_hit(e_hit), .e_busy(e_busy), .q_rank(q_rank),
      .found(found), .sel_idx(sel_idx)
   );
endmodule

// File: rtl/mrs_sched_chk.sv
module mrs_sched_chk #(
   parameter int DEPTH    = 8,
   parameter int BANKS    = 4,
   parameter int BANK_W   = 2,
   parameter int IDX_W    = 3,
   parameter int WR_HIWAT = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        sched_mode,
   input logic                        enq_valid,
   input logic                        enq_ready,
   input logic                        iss_valid,
   input logic                        iss_ready,
   input logic [BANK_W-1:0]           iss_bank,
   input logic                        iss_write,
   input logic [BANKS-1:0]            bank_busy,
   input logic [DEPTH-1:0]            q_valid,
   input logic [DEPTH-1:0]            q_write,
   input logic [DEPTH-1:0][IDX_W-1:0] q_rank,
   input logic [IDX_W-1:0]            sel_idx
);
   assert_idle_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid == '0) |-> !iss_valid);

   assert_full_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && !enq_ready && !(iss_valid && iss_ready)) |=> $stable(q_valid));

   assert_arrival_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sched_mode && iss_valid) |-> (q_rank[sel_idx] == '0));

   assert_no_busy_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> !bank_busy[iss_bank]);

   assert_write_holdback_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sched_mode && iss_valid && iss_write && ($countones(q_valid & q_write) < WR_HIWAT))
      |-> ($countones(q_valid & ~q_write) == 0));

   assert_drain_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sched_mode && iss_valid && ($countones(q_valid & q_write) >= WR_HIWAT)) |-> iss_write);

   assert_issue_removes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=>
      ($countones(q_valid) == $past($countones(q_valid)) - 1 + ($past(enq_valid && enq_ready) ? 1 : 0)));
endmodule

bind mem_req_sched mrs_sched_chk #(
   .DEPTH(DEPTH), .BANKS(BANKS), .BANK_W(BANK_W), .IDX_W(IDX_W), .WR_HIWAT(WR_HIWAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sched_mode(sched_mode),
   .enq_valid(enq_valid), .enq_ready(enq_ready),
   .iss_valid(iss_valid), .iss_ready(iss_ready),
   .iss_bank(iss_bank), .iss_write(iss_write), .bank_busy(bank_busy),
   .q_valid(q_valid), .q_write(q_write), .q_rank(q_rank), .sel_idx(sel_idx)
);

// File: tb/mem_req_sched_tb.sv
module mem_req_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;
   localparam int BANKS = 4;
   localparam int ROW_W = 8;
   localparam int TAG_W = 8;
   localparam int HIWAT = 4;
   localparam int WD_CYCLES = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sched_mode = 1'b0;
   logic enq_valid = 1'b0;
   logic enq_ready;
   logic [1:0] enq_bank = '0;
   logic [ROW_W-1:0] enq_row = '0;
   logic enq_write = 1'b0;
   logic [TAG_W-1:0] enq_tag = '0;
   logic [BANKS-1:0] bank_open = '0;
   logic [BANKS-1:0][ROW_W-1:0] rows = '0;
   logic [BANKS-1:0] bank_busy = '0;
   logic iss_valid;
   logic iss_ready = 1'b0;
   logic [1:0] iss_bank;
   logic [ROW_W-1:0] iss_row;
   logic iss_write;
   logic [TAG_W-1:0] iss_tag;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   mem_req_sched #(
      .DEPTH(DEPTH), .BANKS(BANKS), .ROW_W(ROW_W), .TAG_W(TAG_W), .WR_HIWAT(HIWAT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .sched_mode(sched_mode),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_bank(enq_bank),
      .enq_row(enq_row), .enq_write(enq_write), .enq_tag(enq_tag),
      .bank_open(bank_open), .bank_row(rows), .bank_busy(bank_busy),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_bank(iss_bank),
      .iss_row(iss_row), .iss_write(iss_write), .iss_tag(iss_tag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_enq(input int bank, input int row, input bit wr, input int tag);
      enq_valid = 1'b1;
      enq_bank  = 2'(bank);
      enq_row   = ROW_W'(row);
      enq_write = wr;
      enq_tag   = TAG_W'(tag);
      @(negedge clk);
      enq_valid = 1'b0;
   endtask

   task automatic expect_issue(input int tag, input string req);
      #1;
      chk(iss_valid === 1'b1, req, int'(iss_valid), 1);
      chk(int'(iss_tag) == tag, req, int'(iss_tag), tag);
      iss_ready = 1'b1;
      @(negedge clk);
      iss_ready = 1'b0;
   endtask

   task automatic expect_idle(input string req);
      #1;
      chk(iss_valid === 1'b0, req, int'(iss_valid), 0);
      @(negedge clk);
   endtask

   task automatic t_reset;
      #1;
      chk(iss_valid === 1'b0, "R1 reset iss_valid", int'(iss_valid), 0);
      chk(enq_ready === 1'b1, "R1 reset enq_ready", int'(enq_ready), 1);
      @(negedge clk);
   endtask

   task automatic t_arrival;
      sched_mode = 1'b0;
      bank_open = 4'b0001; rows[0] = 8'd9;
      do_enq(0, 5, 1'b0, 1);
      do_enq(1, 7, 1'b1, 2);
      do_enq(0, 9, 1'b0, 3);
      // R9: offer held while ready is low, fields preserved
      repeat (2) @(negedge clk);
      #1;
      chk(iss_valid === 1'b1 && iss_tag == 8'd1, "R9 hold tag", int'(iss_tag), 1);
      chk(iss_bank == 2'd0 && iss_row == 8'd5 && iss_write == 1'b0, "R9 fields",
          int'({iss_bank, iss_row, iss_write}), 10);
      // R3: oldest bank busy stalls strict order
      bank_busy = 4'b0001;
      expect_idle("R3 busy head stalls");
      bank_busy = '0;
      expect_issue(1, "R3 oldest first");
      expect_issue(2, "R3 write before younger hit");
      expect_issue(3, "R3 last");
      expect_idle("R9 removed after issue");
      bank_open = '0;
   endtask

   task automatic t_hits;
      sched_mode = 1'b1;
      bank_open = 4'b0011; rows[0] = 8'd2; rows[1] = 8'd3;
      do_enq(0, 1, 1'b0, 10);
      do_enq(0, 2, 1'b0, 11);
      expect_issue(11, "R4 hit before older miss");
      expect_issue(10, "R4 miss afterwards");
      do_enq(1, 9, 1'b0, 14);
      do_enq(1, 3, 1'b0, 12);
      do_enq(1, 3, 1'b0, 13);
      expect_issue(12, "R4 older hit first");
      expect_issue(13, "R5 next hit by age");
      expect_issue(14, "R5 miss last");
      bank_open = '0;
      do_enq(2, 1, 1'b0, 15);
      do_enq(3, 1, 1'b0, 16);
      expect_issue(15, "R5 oldest miss");
      expect_issue(16, "R5 younger miss");
   endtask

   task automatic t_busy;
      sched_mode = 1'b1;
      do_enq(2, 0, 1'b0, 20);
      do_enq(3, 0, 1'b0, 21);
      bank_busy = 4'b0100;
      expect_issue(21, "R6 skip busy bank");
      expect_idle("R6 only busy left");
      bank_busy = '0;
      expect_issue(20, "R6 after release");
   endtask

   task automatic t_holdback;
      sched_mode = 1'b1;
      do_enq(0, 0, 1'b1, 30);
      do_enq(1, 0, 1'b0, 31);
      expect_issue(31, "R7 read before older write");
      expect_issue(30, "R7 write once reads gone");
      do_enq(0, 0, 1'b1, 32);
      do_enq(1, 0, 1'b0, 33);
      bank_busy = 4'b0010;
      expect_idle("R7 write held behind blocked read");
      bank_busy = '0;
      expect_issue(33, "R7 read released");
      expect_issue(32, "R7 write last");
   endtask

   task automatic t_drain;
      sched_mode = 1'b1;
      do_enq(0, 0, 1'b1, 40);
      do_enq(1, 0, 1'b1, 41);
      do_enq(2, 0, 1'b1, 42);
      do_enq(3, 0, 1'b1, 43);
      do_enq(0, 0, 1'b0, 44);
      expect_issue(40, "R8 drain at high water");
      expect_issue(44, "R8 read after drop below");
      expect_issue(41, "R8 write 41");
      expect_issue(42, "R8 write 42");
      expect_issue(43, "R8 write 43");
   endtask

   task automatic t_open_flag;
      sched_mode = 1'b1;
      bank_open = '0; rows[0] = 8'd6;
      do_enq(0, 4, 1'b0, 50);
      do_enq(0, 6, 1'b0, 51);
      expect_issue(50, "R10 closed bank no hit");
      expect_issue(51, "R10 second");
      bank_open = 4'b0001;
      do_enq(0, 4, 1'b0, 52);
      do_enq(0, 6, 1'b0, 53);
      expect_issue(53, "R10 open bank hit");
      expect_issue(52, "R10 miss after");
      bank_open = '0;
   endtask

   task automatic t_full;
      sched_mode = 1'b0;
      for (int i = 0; i < DEPTH; i++) do_enq(i % BANKS, 0, 1'b0, 60 + i);
      #1;
      chk(enq_ready === 1'b0, "R2 full blocks enqueue", int'(enq_ready), 0);
      do_enq(1, 1, 1'b0, 99);
      for (int i = 0; i < DEPTH; i++) expect_issue(60 + i, "R2 drain in order");
      expect_idle("R2 dropped request absent");
      #1;
      chk(enq_ready === 1'b1, "R2 ready when empty", int'(enq_ready), 1);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_arrival();
      t_hits();
      t_busy();
      t_holdback();
      t_drain();
      t_open_flag();
      t_full();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule